// File: doc/BRIEF.md
# Timebase Prescaler Timer

The block is a free-running binary prescaler, clocked by the main oscillator, that serves as a shared time reference. A handful of its low counter bits leave the block as divided tap clocks for peripherals. A selectable counter tap raises a periodic interval-interrupt flag. The same counter measures the oscillator settling time after the main clock comes back from stop mode, and the block reports the end of that wait on a ready output.

Software reaches the block through a single control write. One strobe carries the interrupt enable, the interval select, the settling-wait select, a flag bit (writing 0 clears the flag) and a counter-clear command. Any clear of the counter, from software or from entry into stop mode, is passed in the same cycle to a companion watchdog as a clear strobe. That keeps the watchdog's period aligned with the taps that clock it.

Top module: `tbt_timebase`

## Requirements
- R1: Reset values: counter zero (all taps low), flag 0, enable 0, interval select 0, wait select 3, ready 0, watchdog clear 0.
- R2: Outside clear and stop, the counter rises by one per clock, and tap_o[i] equals counter bit i+1.
- R3: The flag sets when 2^(12+2*isel) counts have elapsed since the last counter clear and at that period afterwards (isel 0,1,2,3 give 2^12, 2^14, 2^16, 2^18).
- R4: irq_o is high exactly when both the flag and the enable are 1.
- R5: A control write with flag bit 0 clears the flag. Writing flag bit 1 leaves it unchanged. A set event in the same cycle as a clearing write wins.
- R6: A control write with the clear bit 1 zeroes the counter at that edge, so every tap is low and the interval restarts from zero.
- R7: wdt_clr_o is high in exactly the cycles in which a counter clear (software or stop) is applied.
- R8: While stop_i is high the counter is held at zero and no interval event occurs.
- R9: osc_ready_o drops at the first edge with stop_i high and rises 2^(11+2*osel) counts after the last stop edge (osel 1,2,3 give 2^13, 2^15, 2^17; osel 0 means one cycle). Once high it stays high until the next stop.
- R10: After reset the settling wait is timed from the release of reset, using the wait select in force when the count is reached.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | main oscillator clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| stop_i | input | 1 | stop mode, main clock halted |
| ctl_we_i | input | 1 | control write strobe |
| ctl_ie_i | input | 1 | interrupt enable value |
| ctl_isel_i | input | 2 | interval tap select |
| ctl_osel_i | input | 2 | settling-wait select |
| ctl_flag_i | input | 1 | flag write bit, 0 clears |
| ctl_cnt_clr_i | input | 1 | counter clear command |
| ie_o | output | 1 | current enable |
| isel_o | output | 2 | current interval select |
| osel_o | output | 2 | current wait select |
| flag_o | output | 1 | interval interrupt flag |
| irq_o | output | 1 | interrupt request |
| tap_o | output | TAP_N | divided tap clocks |
| wdt_clr_o | output | 1 | watchdog clear strobe |
| osc_ready_o | output | 1 | settling wait complete |

## Verification
On every cycle the assertions check the following: the counter steps by one or returns to zero after a clear, the taps are low after a clear, the flag obeys set-over-clear priority and rises only on a set event, and no interval event fires during stop. They also check that the ready output falls in stop and never falls otherwise. The tap-select arithmetic can only be shown by the bench scenarios. Those scenarios cover the exact cycles at which the flag and the ready output rise for each select, timed from reset, a software clear or the last stop edge, and the enable gating of the interrupt.

// File: rtl/tbt_pkg.sv
package tbt_pkg;

  typedef struct packed {
    logic       ie;
    logic [1:0] isel;
    logic [1:0] osel;
  } tbt_ctl_t;

  // log2 of the interval period for a given select
  function automatic int irq_span_log2(input int base, input logic [1:0] sel);
    return base + 2 * int'(sel);
  endfunction

  // log2 of the settling wait; 0 encodes "no wait"
  function automatic int osc_span_log2(input int base, input logic [1:0] sel);
    return (sel == 2'd0) ? 0 : base + 2 * (int'(sel) - 1);
  endfunction

endpackage

// File: rtl/tbt_prescaler.sv
module tbt_prescaler #(
  parameter int CNT_W  = 18,
  parameter int TAP_LO = 1,
  parameter int TAP_N  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  output logic [CNT_W:1]   carry_o,
  output logic [TAP_N-1:0] tap_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             inc;

  assign inc = ~clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end

  // carry_o[k]: the low k bits wrap at this edge, i.e. 2^k counts elapsed
  for (genvar k = 1; k <= CNT_W; k++) begin : g_carry
    assign carry_o[k] = inc & (&cnt_q[k-1:0]);
  end

  for (genvar i = 0; i < TAP_N; i++) begin : g_tap
    assign tap_o[i] = cnt_q[TAP_LO+i];
  end

  // R6
  cnt_zero_after_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));
  // R2
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/tbt_intflag.sv
module tbt_intflag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_wr_i,
  input  logic ie_i,
  output logic flag_o,
  output logic irq_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       flag_q <= 1'b0;
    else if (set_i)    flag_q <= 1'b1;
    else if (clr_wr_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & ie_i;

  // R5
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_o);
  // R5
  clr_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_wr_i && !set_i) |=> !flag_o);
  // R3
  flag_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_o) |-> $past(set_i));
endmodule

// File: rtl/tbt_oscwait.sv
module tbt_oscwait #(
  parameter int CNT_W    = 18,
  parameter int OSC_BASE = 13
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           stop_i,
  input  logic [1:0]     osel_i,
  input  logic [CNT_W:1] carry_i,
  output logic           done_evt_o,
  output logic           ready_o
);
  import tbt_pkg::*;
  localparam int IDX_W = $clog2(CNT_W + 1);

  int               span;
  logic [IDX_W-1:0] idx;
  logic             ready_q;

  always_comb begin
    span = osc_span_log2(OSC_BASE, osel_i);
    idx  = IDX_W'(span);
    if (span == 0)           done_evt_o = 1'b1;
    else if (span <= CNT_W)  done_evt_o = carry_i[idx];
    else                     done_evt_o = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         ready_q <= 1'b0;
    else if (stop_i)     ready_q <= 1'b0;
    else if (done_evt_o) ready_q <= 1'b1;
  end

  assign ready_o = ready_q;

  // R9
  ready_low_in_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !ready_o);
  // R9
  ready_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !stop_i) |=> ready_o);
endmodule

// File: rtl/tbt_timebase.sv
module tbt_timebase #(
  parameter int CNT_W    = 18,
  parameter int IRQ_BASE = 12,
  parameter int OSC_BASE = 13,
  parameter int TAP_LO   = 1,
  parameter int TAP_N    = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stop_i,
  input  logic             ctl_we_i,
  input  logic             ctl_ie_i,
  input  logic [1:0]       ctl_isel_i,
  input  logic [1:0]       ctl_osel_i,
  input  logic             ctl_flag_i,
  input  logic             ctl_cnt_clr_i,
  output logic             ie_o,
  output logic [1:0]       isel_o,
  output logic [1:0]       osel_o,
  output logic             flag_o,
  output logic             irq_o,
  output logic [TAP_N-1:0] tap_o,
  output logic             wdt_clr_o,
  output logic             osc_ready_o
);
  import tbt_pkg::*;
  localparam int IDX_W = $clog2(CNT_W + 1);

  tbt_ctl_t         ctl_q;
  logic [CNT_W:1]   carry;
  logic             sw_clr, cnt_clr, flag_clr_wr, irq_evt, osc_done_evt;
  int               irq_span;
  logic [IDX_W-1:0] irq_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ctl_q <= '{ie: 1'b0, isel: 2'd0, osel: 2'd3};
    else if (ctl_we_i) ctl_q <= '{ie: ctl_ie_i, isel: ctl_isel_i, osel: ctl_osel_i};
  end

  assign sw_clr      = ctl_we_i & ctl_cnt_clr_i;
  assign cnt_clr     = sw_clr | stop_i;
  assign flag_clr_wr = ctl_we_i & ~ctl_flag_i;
  assign wdt_clr_o   = cnt_clr;

  always_comb begin
    irq_span = irq_span_log2(IRQ_BASE, ctl_q.isel);
    irq_idx  = IDX_W'(irq_span);
    irq_evt  = (irq_span <= CNT_W) ? carry[irq_idx] : 1'b0;
  end

  tbt_prescaler #(.CNT_W(CNT_W), .TAP_LO(TAP_LO), .TAP_N(TAP_N)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(cnt_clr),
    .carry_o(carry), .tap_o(tap_o));

  tbt_intflag u_flag (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(irq_evt), .clr_wr_i(flag_clr_wr),
    .ie_i(ctl_q.ie), .flag_o(flag_o), .irq_o(irq_o));

  tbt_oscwait #(.CNT_W(CNT_W), .OSC_BASE(OSC_BASE)) u_osc (
    .clk_i(clk_i), .rst_ni(rst_ni), .stop_i(stop_i), .osel_i(ctl_q.osel),
    .carry_i(carry), .done_evt_o(osc_done_evt), .ready_o(osc_ready_o));

  assign ie_o   = ctl_q.ie;
  assign isel_o = ctl_q.isel;
  assign osel_o = ctl_q.osel;

  // R6
  tap_low_after_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_clr_o |=> (tap_o == '0));
  // R8
  no_event_in_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |-> !irq_evt);
  // R9
  no_done_in_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && osc_done_evt) |=> !osc_ready_o);
endmodule

// File: tb/sim_tbt_timebase.sv
`timescale 1ns/1ps
module sim_tbt_timebase;
  localparam int TAP_N = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stop = 1'b0, we = 1'b0, ie = 1'b0, flagw = 1'b1, clr = 1'b0;
  logic [1:0] isel = 2'd0, osel = 2'd0;
  logic ie_o, flag_o, irq_o, wdt_clr_o, ready_o;
  logic [1:0] isel_o, osel_o;
  logic [TAP_N-1:0] tap_o;

  int cyc = 0;
  int checks = 0;
  int fails = 0;

  typedef struct {
    int    at;
    int    kind;
    int    val;
    string req;
  } exp_t;
  exp_t sb[$];

  localparam int K_FLAG = 0, K_IRQ = 1, K_READY = 2, K_WDT = 3, K_TAP = 4,
                 K_IE = 5, K_ISEL = 6, K_OSEL = 7;

  tbt_timebase u0 (
    .clk_i(clk), .rst_ni(rst_n), .stop_i(stop), .ctl_we_i(we), .ctl_ie_i(ie),
    .ctl_isel_i(isel), .ctl_osel_i(osel), .ctl_flag_i(flagw), .ctl_cnt_clr_i(clr),
    .ie_o(ie_o), .isel_o(isel_o), .osel_o(osel_o), .flag_o(flag_o), .irq_o(irq_o),
    .tap_o(tap_o), .wdt_clr_o(wdt_clr_o), .osc_ready_o(ready_o));

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int observe(int k);
    case (k)
      K_FLAG:  return int'(flag_o);
      K_IRQ:   return int'(irq_o);
      K_READY: return int'(ready_o);
      K_WDT:   return int'(wdt_clr_o);
      K_TAP:   return int'(tap_o);
      K_IE:    return int'(ie_o);
      K_ISEL:  return int'(isel_o);
      default: return int'(osel_o);
    endcase
  endfunction

  // driver side: queue an expectation, kept in cycle order
  task automatic expect_at(int at, int kind, int val, string req);
    exp_t e;
    int pos;
    e.at = at; e.kind = kind; e.val = val; e.req = req;
    pos = sb.size();
    for (int i = 0; i < sb.size(); i++) begin
      if (sb[i].at > at) begin pos = i; break; end
    end
    sb.insert(pos, e);
  endtask

  // monitor: compare at the falling edge of the expected cycle
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].at <= cyc) begin
      exp_t e;
      int got;
      e = sb.pop_front();
      checks++;
      got = observe(e.kind);
      if (e.at < cyc) begin
        fails++;
        $display("FAIL %s: kind %0d at cycle %0d missed, actual %0d expected %0d",
                 e.req, e.kind, e.at, got, e.val);
      end else if (got != e.val) begin
        fails++;
        $display("FAIL %s: kind %0d at cycle %0d actual %0d expected %0d",
                 e.req, e.kind, e.at, got, e.val);
      end
    end
  end

  task automatic wait_cyc(int c);
    while (cyc < c) @(negedge clk);
    #1;
  endtask

  task automatic ctl_wr(logic v_ie, logic [1:0] v_isel, logic [1:0] v_osel,
                        logic v_flag, logic v_clr);
    we = 1'b1; ie = v_ie; isel = v_isel; osel = v_osel; flagw = v_flag; clr = v_clr;
    @(negedge clk); #1;
    we = 1'b0; clr = 1'b0; flagw = 1'b1;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    wait (cyc >= 150000);
    fails++; checks++;
    $display("FAIL watchdog: run hung, actual cycle %0d expected end before it", cyc);
    summary();
  end

  localparam int R0 = 4;          // reset released after this cycle
  localparam int E  = 9001;       // software clear edge
  localparam int T1 = 26040;      // last stop edge, osel=1
  localparam int T3 = 43120;      // last stop edge, osel=2

  initial begin
    // R1 reset values
    expect_at(3, K_TAP, 0, "R1");   expect_at(3, K_FLAG, 0, "R1");
    expect_at(3, K_IE, 0, "R1");    expect_at(3, K_ISEL, 0, "R1");
    expect_at(3, K_OSEL, 3, "R1");  expect_at(3, K_READY, 0, "R1");
    expect_at(3, K_IRQ, 0, "R1");   expect_at(3, K_WDT, 0, "R1");
    // R2 taps follow counter bits 1..4; counter = cycle - R0
    expect_at(R0 + 5, K_TAP, 2, "R2");
    expect_at(R0 + 13, K_TAP, 6, "R2");
    expect_at(11, K_IE, 1, "R1");   expect_at(11, K_OSEL, 1, "R10");
    // R3 / R4 first interval with isel 0
    expect_at(R0 + 4095, K_FLAG, 0, "R3");
    expect_at(R0 + 4096, K_FLAG, 1, "R3");
    expect_at(R0 + 4096, K_IRQ, 1, "R4");
    // R5 writes
    expect_at(4201, K_FLAG, 1, "R5");
    expect_at(4301, K_FLAG, 0, "R5");
    expect_at(4301, K_IRQ, 0, "R4");
    expect_at(R0 + 8192, K_FLAG, 1, "R5");
    // R10 wait timed from reset, osel changed to 1 before completion
    expect_at(R0 + 8191, K_READY, 0, "R10");
    expect_at(R0 + 8192, K_READY, 1, "R10");
    // R4 enable gating
    expect_at(8301, K_FLAG, 1, "R4");
    expect_at(8301, K_IRQ, 0, "R4");
    // R6 / R7 software clear
    expect_at(E - 1, K_WDT, 0, "R7");
    expect_at(E, K_WDT, 1, "R7");   expect_at(E, K_TAP, 0, "R6");
    expect_at(E + 1, K_WDT, 0, "R7");
    expect_at(E + 3, K_TAP, 1, "R6");
    expect_at(E + 10, K_READY, 1, "R9");
    expect_at(E + 1, K_ISEL, 1, "R3");
    expect_at(E + 4096, K_FLAG, 0, "R3");
    expect_at(E + 16383, K_FLAG, 0, "R6");
    expect_at(E + 16384, K_FLAG, 1, "R6");
    expect_at(E + 16384, K_IRQ, 1, "R4");
    // R8 / R9 stop with osel 1
    expect_at(26001, K_FLAG, 0, "R5");
    expect_at(26011, K_WDT, 1, "R7");
    expect_at(26011, K_READY, 0, "R9");
    expect_at(26020, K_TAP, 0, "R8");
    expect_at(T1 - 1, K_TAP, 0, "R8");
    expect_at(T1 - 1, K_FLAG, 0, "R8");
    expect_at(T1, K_WDT, 1, "R7");
    expect_at(T1 + 1, K_WDT, 0, "R7");
    expect_at(T1 + 5, K_TAP, 2, "R8");
    expect_at(T1 + 8191, K_READY, 0, "R9");
    expect_at(T1 + 8192, K_READY, 1, "R9");
    expect_at(T1 + 16383, K_FLAG, 0, "R8");
    expect_at(T1 + 16384, K_FLAG, 1, "R8");
    // R9 osel 0: ready one cycle after stop exit
    expect_at(43020, K_READY, 0, "R9");
    expect_at(43021, K_READY, 1, "R9");
    // R9 osel 2
    expect_at(43101, K_OSEL, 2, "R9");
    expect_at(T3 + 32767, K_READY, 0, "R9");
    expect_at(T3 + 32768, K_READY, 1, "R9");
    expect_at(80000, K_READY, 1, "R9");

    wait_cyc(R0);  rst_n = 1'b1;
    wait_cyc(10);  ctl_wr(1'b1, 2'd0, 2'd1, 1'b1, 1'b0);
    wait_cyc(4200); ctl_wr(1'b1, 2'd0, 2'd1, 1'b1, 1'b0);
    wait_cyc(4300); ctl_wr(1'b1, 2'd0, 2'd1, 1'b0, 1'b0);
    wait_cyc(R0 + 8191); ctl_wr(1'b1, 2'd0, 2'd1, 1'b0, 1'b0);
    wait_cyc(8300); ctl_wr(1'b0, 2'd0, 2'd1, 1'b1, 1'b0);
    wait_cyc(E - 1); ctl_wr(1'b1, 2'd1, 2'd1, 1'b0, 1'b1);
    wait_cyc(26000); ctl_wr(1'b1, 2'd1, 2'd1, 1'b0, 1'b0);
    wait_cyc(26010); stop = 1'b1;
    wait_cyc(T1);    stop = 1'b0;
    wait_cyc(43000); ctl_wr(1'b1, 2'd1, 2'd0, 1'b1, 1'b0);
    wait_cyc(43010); stop = 1'b1;
    wait_cyc(43020); stop = 1'b0;
    wait_cyc(43100); ctl_wr(1'b1, 2'd1, 2'd2, 1'b1, 1'b0);
    wait_cyc(43110); stop = 1'b1;
    wait_cyc(T3);    stop = 1'b0;
    wait_cyc(80010);
    if (sb.size() != 0) begin
      checks++; fails++;
      $display("FAIL R1: %0d expectations left, actual %0d expected 0", sb.size(), sb.size());
    end
    summary();
  end
endmodule